// File: doc/BRIEF.md
# Clock-reset control register block

This block is the software-visible register bank of a clock and reset domain controller. A host reads and writes 32-bit words over a simple single-cycle bus. The bank holds three PLL control words, a memory clock control word, a peripheral reset word and a per-core reset word. It also holds a constant PLL status word and a small interrupt unit. None of the stored clock fields drives a real clock: they are storage only. The PLL status always reports every PLL as locked and stable.

The interrupt unit has one source, an address decode error. The mask can only be changed through two write-only aliases: one clears mask bits and one sets them. An access to an offset that is not mapped, including any offset that is not word aligned, records the error. If the error control bit is set, the access also gets a bus error response.

The bank watches the low four bits of the core reset word. When a write changes one of them, the bank sends the core controller a one-cycle power-off request or a one-cycle power-on-with-reset request for that core.

Top module: `clkrst_regs`

## Requirements
- R1: After reset the words read as follows. Offset 0x00 (error control) reads 0. Offset 0x04 (interrupt status) reads 0. Offset 0x08 (interrupt mask) reads 1. The PLL control words at 0x20, 0x2C and 0x38 read 0x12C09, 0x2C09 and 0x12809. The memory clock word at 0x80 reads 0x1000500. The peripheral reset word at 0x100 reads 0xF9FFE. The core reset word at 0x104 reads 0x3D0F. The outputs irq, bus_err, core_off and core_on are 0.
- R2: An access is one cycle with bus_sel high, and bus_wr selects a write. The read value appears on bus_rdata in the cycle after a read, and bus_rdata is 0 after a write. Addresses are byte offsets. An offset whose bits 1..0 are not 00 is unmapped.
- R3: A direct write to the mask at 0x08 has no effect. Writing 1 in bit 0 of the alias at 0x0C clears the mask bit. Writing 1 in bit 0 of the alias at 0x10 sets it. Writing 0 to either alias changes nothing. Both aliases read as 0.
- R4: irq is high exactly when status bit 0 is 1 and mask bit 0 is 0. It reflects an access from the cycle after that access.
- R5: Any access to an unmapped offset sets status bit 0. A write to 0x04 with bit 0 at 1 clears it. A write to 0x04 with bit 0 at 0 leaves it unchanged.
- R6: In the cycle after an unmapped access, bus_err is 1 if error-control bit 0 was 1 when the access was made, and 0 otherwise. Mapped accesses never give bus_err. The mapped offsets are 0x00, 0x04, 0x08, 0x0C, 0x10, 0x20, 0x2C, 0x38, 0x44, 0x80, 0x100 and 0x104.
- R7: Take a write to 0x104 in which bit i (i = 0..3) of the written data differs from the stored bit i. In the next cycle the bank raises a one-cycle pulse for that core: core_off[i] if the new bit is 1, or core_on[i] if the new bit is 0. In every other cycle the pulse bits are 0.
- R8: The PLL status word at 0x44 always reads 0x3F, and writes to it are ignored.
- R9: Reserved bits read as 0 and ignore writes. The writable masks are 0x07737F09 for the PLL control words, 0x01003F07 at 0x80, 0x000F9FFE at 0x100, 0x00003D0F at 0x104 and 0x1 at 0x00.
- R10: A write to 0x104 that leaves bits 3..0 unchanged produces no core pulse, even if other bits change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_err | output | 1 | Error response, one cycle after the access |
| irq | output | 1 | Level interrupt |
| core_off | output | NCORE | Per-core power-off request pulse |
| core_on | output | NCORE | Per-core power-on-with-reset request pulse |

## Verification
Every result of an access is due in the cycle right after it: read data, the error response, a core pulse and the new interrupt level. The bench drives each access on a falling edge and compares all four results on the next falling edge, once the single register stage has updated. A core pulse is also checked to be gone on the following idle cycle. Expected values come from a bench model of the bank that is updated with the same access as the design.

// File: rtl/clkrst_regs.sv
module clkrst_regs #(
  parameter int ADDR_W = 12,
  parameter int NCORE  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  output logic              irq,
  output logic [NCORE-1:0]  core_off,
  output logic [NCORE-1:0]  core_on
);
  localparam int NPLL = 3;
  localparam logic [ADDR_W-1:0] O_ERR  = ADDR_W'(32'h000);
  localparam logic [ADDR_W-1:0] O_STAT = ADDR_W'(32'h004);
  localparam logic [ADDR_W-1:0] O_MASK = ADDR_W'(32'h008);
  localparam logic [ADDR_W-1:0] O_IEN  = ADDR_W'(32'h00C);
  localparam logic [ADDR_W-1:0] O_IDIS = ADDR_W'(32'h010);
  localparam logic [ADDR_W-1:0] O_PST  = ADDR_W'(32'h044);
  localparam logic [ADDR_W-1:0] O_MEM  = ADDR_W'(32'h080);
  localparam logic [ADDR_W-1:0] O_TOP  = ADDR_W'(32'h100);
  localparam logic [ADDR_W-1:0] O_CORE = ADDR_W'(32'h104);
  localparam logic [ADDR_W-1:0] PLL_OFF [NPLL] = '{ADDR_W'(32'h20), ADDR_W'(32'h2C), ADDR_W'(32'h38)};
  localparam logic [31:0] PLL_RST [NPLL] = '{32'h00012C09, 32'h00002C09, 32'h00012809};
  localparam logic [31:0] PLL_WM  = ~32'hF88C80F6;
  localparam logic [31:0] MEM_WM  = ~32'hFEFFC0F8;
  localparam logic [31:0] MEM_RST = 32'h01000500;
  localparam logic [31:0] TOP_WM  = 32'h000F9FFE;
  localparam logic [31:0] TOP_RST = 32'h000F9FFE;
  localparam logic [31:0] CORE_WM = 32'h00003D0F;
  localparam logic [31:0] CORE_RST = 32'h00003D0F;
  localparam logic [31:0] PLL_STAT = 32'h0000003F;

  logic        err_en, stat, mask;
  logic [31:0] pll_q [NPLL];
  logic [31:0] mem_q, top_q, core_q;
  logic [31:0] rd_val;
  logic        hit;

  always_comb begin
    rd_val = '0;
    hit    = 1'b0;
    for (int i = 0; i < NPLL; i++)
      if (bus_addr == PLL_OFF[i]) begin
        hit    = 1'b1;
        rd_val = pll_q[i];
      end
    case (bus_addr)
      O_ERR:  begin hit = 1'b1; rd_val = {31'b0, err_en}; end
      O_STAT: begin hit = 1'b1; rd_val = {31'b0, stat}; end
      O_MASK: begin hit = 1'b1; rd_val = {31'b0, mask}; end
      O_IEN, O_IDIS: hit = 1'b1;
      O_PST:  begin hit = 1'b1; rd_val = PLL_STAT; end
      O_MEM:  begin hit = 1'b1; rd_val = mem_q; end
      O_TOP:  begin hit = 1'b1; rd_val = top_q; end
      O_CORE: begin hit = 1'b1; rd_val = core_q; end
      default: ;
    endcase
  end

  wire             wr       = bus_sel && bus_wr;
  wire             unmapped = bus_sel && !hit;
  wire             core_wr  = wr && (bus_addr == O_CORE);
  wire [NCORE-1:0] core_new = bus_wdata[NCORE-1:0];
  wire [NCORE-1:0] core_chg = core_new ^ core_q[NCORE-1:0];

  assign irq = stat && !mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      core_off  <= '0;
      core_on   <= '0;
      err_en    <= 1'b0;
      stat      <= 1'b0;
      mask      <= 1'b1;
      mem_q     <= MEM_RST;
      top_q     <= TOP_RST;
      core_q    <= CORE_RST;
      for (int i = 0; i < NPLL; i++) pll_q[i] <= PLL_RST[i];
    end else begin
      bus_rdata <= (bus_sel && !bus_wr) ? rd_val : '0;
      bus_err   <= unmapped && err_en;
      core_off  <= core_wr ? (core_chg & core_new) : '0;
      core_on   <= core_wr ? (core_chg & ~core_new) : '0;
      if (unmapped) stat <= 1'b1;
      else if (wr && bus_addr == O_STAT && bus_wdata[0]) stat <= 1'b0;
      if (wr) begin
        for (int i = 0; i < NPLL; i++)
          if (bus_addr == PLL_OFF[i]) pll_q[i] <= bus_wdata & PLL_WM;
        case (bus_addr)
          O_ERR:  err_en <= bus_wdata[0];
          O_IEN:  if (bus_wdata[0]) mask <= 1'b0;
          O_IDIS: if (bus_wdata[0]) mask <= 1'b1;
          O_MEM:  mem_q  <= bus_wdata & MEM_WM;
          O_TOP:  top_q  <= bus_wdata & TOP_WM;
          O_CORE: core_q <= bus_wdata & CORE_WM;
          default: ;
        endcase
      end
    end
  end

  p_mask_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == O_MASK) |=> $stable(mask));
  p_err_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(err_en));
  p_stat_on_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> stat);
  p_pulse_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_off || |core_on) |-> $past(core_wr));
  p_pll_const_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == O_PST) |=> (bus_rdata == PLL_STAT));
endmodule

// File: tb/clkrst_regs_bench.sv
module clkrst_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, irq;
  logic [3:0]  core_off, core_on;

  int n_chk = 0, n_fail = 0;

  clkrst_regs #(.ADDR_W(12), .NCORE(4)) u_clkrst_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq(irq), .core_off(core_off), .core_on(core_on));

  always #2 clk = ~clk;

  logic        m_err, m_stat, m_mask;
  logic [31:0] m_pll [3];
  logic [31:0] m_mem, m_top, m_core;

  task automatic model_reset();
    m_err = 0; m_stat = 0; m_mask = 1;
    m_pll[0] = 32'h12C09; m_pll[1] = 32'h2C09; m_pll[2] = 32'h12809;
    m_mem = 32'h1000500; m_top = 32'hF9FFE; m_core = 32'h3D0F;
  endtask

  function automatic bit mapped(input logic [11:0] a);
    case (a)
      12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h020, 12'h02C,
      12'h038, 12'h044, 12'h080, 12'h100, 12'h104: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] mread(input logic [11:0] a);
    case (a)
      12'h000: return {31'b0, m_err};
      12'h004: return {31'b0, m_stat};
      12'h008: return {31'b0, m_mask};
      12'h020: return m_pll[0];
      12'h02C: return m_pll[1];
      12'h038: return m_pll[2];
      12'h044: return 32'h3F;
      12'h080: return m_mem;
      12'h100: return m_top;
      12'h104: return m_core;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d, input string tag);
    logic [31:0] e_rd;
    logic        e_err;
    logic [3:0]  e_off, e_on, nv, df;
    e_rd  = wr ? 32'h0 : mread(a);
    e_err = !mapped(a) && m_err;
    e_off = 4'h0; e_on = 4'h0;
    if (!mapped(a)) m_stat = 1'b1;
    if (wr) begin
      case (a)
        12'h000: m_err = d[0];
        12'h004: if (d[0]) m_stat = 1'b0;
        12'h00C: if (d[0]) m_mask = 1'b0;
        12'h010: if (d[0]) m_mask = 1'b1;
        12'h020: m_pll[0] = d & 32'h07737F09;
        12'h02C: m_pll[1] = d & 32'h07737F09;
        12'h038: m_pll[2] = d & 32'h07737F09;
        12'h080: m_mem = d & 32'h01003F07;
        12'h100: m_top = d & 32'h000F9FFE;
        12'h104: begin
          nv = d[3:0]; df = nv ^ m_core[3:0];
          e_off = df & nv; e_on = df & ~nv;
          m_core = d & 32'h3D0F;
        end
        default: ;
      endcase
    end
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0;
    check(bus_rdata == e_rd, tag, bus_rdata, e_rd);
    check(bus_err == e_err, "R6", {31'b0, bus_err}, {31'b0, e_err});
    check(irq == (m_stat && !m_mask), "R4", {31'b0, irq}, {31'b0, m_stat && !m_mask});
    check(core_off == e_off, "R7", {28'b0, core_off}, {28'b0, e_off});
    check(core_on == e_on, "R7", {28'b0, core_on}, {28'b0, e_on});
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    check(core_off == 4'h0 && core_on == 4'h0, tag, {24'b0, core_off, core_on}, 32'h0);
  endtask

  localparam logic [11:0] MAPS [12] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h020,
                                        12'h02C, 12'h038, 12'h044, 12'h080, 12'h100, 12'h104};

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset outputs
    check(irq == 0 && bus_err == 0 && core_off == 0 && core_on == 0, "R1",
          {28'b0, irq, bus_err, |core_off, |core_on}, 32'h0);
    foreach (MAPS[i]) access(1'b0, MAPS[i], 32'h0, "R1");
    // R6 disabled error, R5 status set, R4 masked
    access(1'b0, 12'h014, 32'h0, "R2");
    access(1'b0, 12'h004, 32'h0, "R5");
    // R3 enable alias unmasks, irq rises
    access(1'b1, 12'h00C, 32'h0, "R3");
    access(1'b0, 12'h008, 32'h0, "R3");
    access(1'b1, 12'h00C, 32'h1, "R3");
    access(1'b0, 12'h008, 32'h0, "R3");
    access(1'b0, 12'h00C, 32'h0, "R3");
    access(1'b1, 12'h008, 32'hFFFFFFFF, "R3");
    access(1'b0, 12'h008, 32'h0, "R3");
    access(1'b1, 12'h010, 32'h1, "R3");
    access(1'b0, 12'h010, 32'h0, "R3");
    access(1'b1, 12'h00C, 32'h1, "R3");
    // R5 write-one-to-clear
    access(1'b1, 12'h004, 32'h0, "R5");
    access(1'b0, 12'h004, 32'h0, "R5");
    access(1'b1, 12'h004, 32'h1, "R5");
    access(1'b0, 12'h004, 32'h0, "R5");
    // R6 enabled error, R2 misaligned
    access(1'b1, 12'h000, 32'hFFFFFFFF, "R9");
    access(1'b0, 12'h000, 32'h0, "R9");
    access(1'b0, 12'h021, 32'h0, "R2");
    access(1'b1, 12'h106, 32'h0, "R2");
    access(1'b1, 12'h104, 32'h3D0F, "R2");
    // R7 core pulses, R10 no change
    access(1'b1, 12'h104, 32'h3D0E, "R7");
    idle_check("R7");
    access(1'b1, 12'h104, 32'h000E, "R10");
    access(1'b0, 12'h104, 32'h0, "R9");
    access(1'b1, 12'h104, 32'hFFFFFFFF, "R7");
    access(1'b0, 12'h104, 32'h0, "R9");
    access(1'b1, 12'h104, 32'h0, "R7");
    idle_check("R7");
    access(1'b1, 12'h104, 32'hA, "R7");
    // R9 reserved bits, R8 status constant
    access(1'b1, 12'h020, 32'hFFFFFFFF, "R9");
    access(1'b0, 12'h020, 32'h0, "R9");
    access(1'b1, 12'h080, 32'hFFFFFFFF, "R9");
    access(1'b0, 12'h080, 32'h0, "R9");
    access(1'b1, 12'h100, 32'hFFFFFFFF, "R9");
    access(1'b0, 12'h100, 32'h0, "R9");
    access(1'b1, 12'h044, 32'h0, "R8");
    access(1'b0, 12'h044, 32'h0, "R8");
    // random mix
    void'($urandom(32'd20240611));
    for (int k = 0; k < 600; k++) begin
      logic [11:0] a;
      logic [31:0] d;
      bit w;
      if ($urandom_range(0, 7) == 0) a = 12'($urandom_range(0, 12'h13F));
      else a = MAPS[$urandom_range(0, 11)];
      d = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 15)) : $urandom;
      w = $urandom_range(0, 1) == 1;
      access(w, a, d, "R2");
      if ($urandom_range(0, 3) == 0) idle_check("R7");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule